// File: doc/BRIEF.md
# Display PLL divisor search engine

This block finds the divisor settings for a display PLL. Software or a mode-setting sequencer gives it a target pixel clock in kHz, an output mode and a core-frequency selection, then pulses `start`. The engine steps through every permitted divisor combination, one candidate per iteration, and keeps the best one. A shared multi-cycle restoring divider computes each quotient. At the end the engine packs the winning divisors into two register-ready words: a divisor word and a PLL-control word. It also raises a found flag when the search met its success rule.

Two modes exist. Panel mode sweeps the feedback divider m (outer loop) and the post divider p1 (inner loop). It takes the reference equal to the core clock and a fixed prescale of 14. The winner is the candidate with the smallest absolute frequency error. Serial-output mode sweeps m, then n, then p1 against a fixed 96 MHz reference and a post divider of 10. It prunes candidates whose VCO falls outside a 1.4 GHz to 2.8 GHz window. It scores each candidate by a relative error in units of 1/10000, and it can abandon loops early. The inputs are captured when the engine accepts `start`. The results stay on the outputs until the next search finishes.

Top module: `pllsrch_top`

## Requirements
- R1: While reset is held, and after it is released, `busy`, `done`, `found`, `div_word` and `ctl_word` are all zero until a search completes.
- R2: An accepted `start` raises `busy` in the next cycle. `busy` stays high for the whole search. `done` is a one-cycle pulse in the cycle in which `busy` falls, and `done` is never high together with `busy`. A `start` while `busy` is high is ignored, and the running search returns the result of its own inputs.
- R3: Panel mode evaluates out = ref·m / (14·p1) with integer division, m in the outer loop and p1 in the inner loop, both ascending. It replaces the best candidate only when |out − target| is strictly below the best error so far, so the earliest of several equal candidates wins.
- R4: `core_sel` picks the panel limits. 0 gives ref 100000 kHz, m 20..34, p1 2..8. 1 gives ref 166000 kHz, m 12..20, p1 2..7. 2 and 3 both give ref 200000 kHz, m 10..17, p1 2..8.
- R5: In panel mode the best error starts at the target value. `found` is 1 exactly when the final best error differs from the target. If no candidate ever improved, both words are zero.
- R6: Panel encoding places an m code at bits 15:8 of `div_word` and zeros elsewhere. The m code is entry m−10 of a 6-bit sequence that starts at 0x2B; each next entry is the previous one shifted right by one, with bit 5 set to (bit 0 XOR bit 5) of the previous entry. `ctl_word` has only bit 17+(p1−2) set.
- R7: Serial mode uses ref 96000 kHz, m 80..137, n 3..7, p1 1..2, with the loop order m, n, p1 (outer to inner). With p = 10·p1 and vco = target·p: vco > 2800000 ends the p1 loop for that (m, n); vco < 1400000 skips the candidate.
- R8: In serial mode actual = 96000·m / (n·p) and err = 10000 − (target·10000)/actual, using signed integer arithmetic. The best error starts at 100000. err < −best ends the p1 loop. Otherwise the candidate replaces the best when |err| < best. After each complete m iteration the search stops if best = 0. `found` = 1 only when best = 0.
- R9: Serial encoding sets `div_word` = (1<<(n−1))<<16 | (m−2) and `ctl_word` = (1<<(p1−1))<<16. If no candidate was ever kept, both words are zero.
- R10: Target, mode and core selection are captured when `start` is accepted. A `start` in the same cycle as `done` is accepted and begins a new search with the new inputs.
- R11: `found`, `div_word` and `ctl_word` change only in the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (accepted when idle) |
| target_khz | input | TGT_W | Requested pixel clock in kHz |
| serial_mode | input | 1 | 0 = panel mode, 1 = serial-output mode |
| core_sel | input | 2 | Core-frequency selection for panel limits |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Success rule of the mode was met |
| div_word | output | 32 | Encoded divisor word of the winner |
| ctl_word | output | 32 | Encoded post-divider field of the control word |

## Verification
Two events can meet in one cycle: the completion of one search and the acceptance of the next `start`. The bench drives `start` with new parameters in exactly the cycle where `done` is seen. It checks that the first result is correct and that the second search returns the reference result for the new inputs, not the old ones. A second collision, a `start` arriving while a search is in progress, is provoked partway through a panel sweep. It is judged by requiring that the returned words still match the first request. Every other result is compared against an arithmetic reference search written inside the bench.

// File: rtl/pllsrch_pkg.sv
package pllsrch_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_EVAL, S_WAIT1, S_WAIT2, S_ADV, S_FIN
  } state_t;

  typedef struct packed {
    logic [17:0] ref_khz;
    logic [7:0]  m_lo;
    logic [7:0]  m_hi;
    logic [3:0]  p1_lo;
    logic [3:0]  p1_hi;
  } lims_t;

  // serial-output mode constants
  localparam int SER_REF_KHZ = 96000;
  localparam int SER_M_LO    = 80;
  localparam int SER_M_HI    = 137;
  localparam int SER_N_LO    = 3;
  localparam int SER_N_HI    = 7;
  localparam int SER_P1_LO   = 1;
  localparam int SER_P1_HI   = 2;
  localparam int SER_POST    = 10;
  localparam int VCO_MIN_KHZ = 1400000;
  localparam int VCO_MAX_KHZ = 2800000;
  localparam int SER_ERR_INIT = 100000;
  localparam int REL_SCALE   = 10000;
  localparam int PANEL_PRE   = 14;
  localparam int PANEL_M_BASE = 10;
  localparam int MCODE_LEN   = 26;

  // panel limits per core-frequency selection (R4)
  function automatic lims_t panel_lims(input logic [1:0] sel);
    lims_t l;
    case (sel)
      2'd0:    l = '{ref_khz: 18'd100000, m_lo: 8'd20, m_hi: 8'd34, p1_lo: 4'd2, p1_hi: 4'd8};
      2'd1:    l = '{ref_khz: 18'd166000, m_lo: 8'd12, m_hi: 8'd20, p1_lo: 4'd2, p1_hi: 4'd7};
      default: l = '{ref_khz: 18'd200000, m_lo: 8'd10, m_hi: 8'd17, p1_lo: 4'd2, p1_hi: 4'd8};
    endcase
    return l;
  endfunction

  // m code sequence for panel encoding (R6): 6-bit right-shifting register
  function automatic logic [5:0] mcode(input int idx);
    logic [5:0] s;
    s = 6'h2B;
    for (int i = 0; i < MCODE_LEN; i++) begin
      if (i < idx) s = {s[5] ^ s[0], s[5:1]};
    end
    return s;
  endfunction

endpackage

// File: rtl/pllsrch_div.sv
module pllsrch_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         ok,
  output logic [W-1:0] quo
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  acc;
  logic [W-1:0]  dv;
  logic [CW-1:0] cnt;
  logic          run;
  logic [W:0]    trial;

  assign trial = {acc, quo[W-1]} - {1'b0, dv};
  assign busy  = run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      dv  <= '0;
      quo <= '0;
      cnt <= '0;
      run <= 1'b0;
      ok  <= 1'b0;
    end else begin
      ok <= 1'b0;
      if (go) begin
        acc <= '0;
        dv  <= den;
        quo <= num;
        cnt <= CW'(W);
        run <= 1'b1;
      end else if (run) begin
        if (!trial[W]) begin
          acc <= trial[W-1:0];
          quo <= {quo[W-2:0], 1'b1};
        end else begin
          acc <= {acc[W-2:0], quo[W-1]};
          quo <= {quo[W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run <= 1'b0;
          ok  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pllsrch_enc.sv
module pllsrch_enc #(
  parameter int WORD_W = 32
) (
  input  logic              serial,
  input  logic              have,
  input  logic [7:0]        m,
  input  logic [2:0]        n,
  input  logic [3:0]        p1,
  output logic [WORD_W-1:0] div_word,
  output logic [WORD_W-1:0] ctl_word
);
  import pllsrch_pkg::*;

  always_comb begin
    div_word = '0;
    ctl_word = '0;
    if (have) begin
      // panel: bit 17+(p1-2); serial: bit 16+(p1-1); both land on bit 15+p1
      ctl_word = WORD_W'(1) << (5'(p1) + 5'd15);
      if (serial)
        div_word = (WORD_W'(1) << (5'(n) + 5'd15)) | WORD_W'(m - 8'd2);
      else
        div_word = WORD_W'(mcode(int'(m) - PANEL_M_BASE)) << 8;
    end
  end
endmodule

// File: rtl/pllsrch_top.sv
module pllsrch_top #(
  parameter int TGT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TGT_W-1:0] target_khz,
  input  logic             serial_mode,
  input  logic [1:0]       core_sel,
  output logic             busy,
  output logic             done,
  output logic             found,
  output logic [31:0]      div_word,
  output logic [31:0]      ctl_word
);
  import pllsrch_pkg::*;

  localparam int DIV_W  = TGT_W + 14;
  localparam int EW     = DIV_W + 2;
  localparam int WORD_W = 32;

  state_t                st;
  logic [TGT_W-1:0]      tgt_q;
  logic                  ser_q;
  lims_t                 lim_q;
  lims_t                 new_lim;
  logic [7:0]            m_q, bm;
  logic [2:0]            n_q, bn;
  logic [3:0]            p1_q, bp;
  logic signed [EW-1:0]  best_err;
  logic                  have_q;
  logic                  brk_q;

  // active loop limits
  logic [7:0] m_hi_w;
  logic [3:0] p1_lo_w, p1_hi_w;
  assign new_lim = panel_lims(core_sel);
  assign m_hi_w  = ser_q ? 8'(SER_M_HI)  : lim_q.m_hi;
  assign p1_lo_w = ser_q ? 4'(SER_P1_LO) : lim_q.p1_lo;
  assign p1_hi_w = ser_q ? 4'(SER_P1_HI) : lim_q.p1_hi;

  // VCO window check (serial)
  logic [DIV_W-1:0] vco_w;
  logic             vco_hi, vco_lo;
  assign vco_w  = DIV_W'(tgt_q) * DIV_W'(p1_q) * DIV_W'(SER_POST);
  assign vco_hi = vco_w > DIV_W'(VCO_MAX_KHZ);
  assign vco_lo = vco_w < DIV_W'(VCO_MIN_KHZ);

  // divider
  logic             div_go, div_busy, div_ok;
  logic [DIV_W-1:0] div_num, div_den, div_q;
  logic [DIV_W-1:0] pnum, pden, snum1, sden1, snum2;

  assign pnum  = DIV_W'(lim_q.ref_khz) * DIV_W'(m_q);
  assign pden  = DIV_W'(PANEL_PRE) * DIV_W'(p1_q);
  assign snum1 = DIV_W'(SER_REF_KHZ) * DIV_W'(m_q);
  assign sden1 = DIV_W'(n_q) * DIV_W'(p1_q) * DIV_W'(SER_POST);
  assign snum2 = DIV_W'(tgt_q) * DIV_W'(REL_SCALE);

  assign div_go  = (st == S_EVAL && (!ser_q || (!vco_hi && !vco_lo))) ||
                   (st == S_WAIT1 && ser_q && div_ok);
  assign div_num = (st == S_WAIT1) ? snum2 : (ser_q ? snum1 : pnum);
  assign div_den = (st == S_WAIT1) ? div_q : (ser_q ? sden1 : pden);

  pllsrch_div #(.W(DIV_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (div_go),
    .num  (div_num),
    .den  (div_den),
    .busy (div_busy),
    .ok   (div_ok),
    .quo  (div_q)
  );

  // candidate scoring
  logic signed [EW-1:0] q_s, t_s, err_raw, err_abs;
  logic                 cand_judge, cand_abandon, cand_improve;
  assign q_s     = $signed({2'b00, div_q});
  assign t_s     = $signed(EW'(tgt_q));
  assign err_raw = ser_q ? ($signed(EW'(REL_SCALE)) - q_s) : (q_s - t_s);
  assign err_abs = (err_raw < 0) ? -err_raw : err_raw;
  assign cand_judge   = div_ok && ((st == S_WAIT1 && !ser_q) || st == S_WAIT2);
  assign cand_abandon = div_ok && st == S_WAIT2 && (err_raw < -best_err);
  assign cand_improve = cand_judge && !cand_abandon && (err_abs < best_err);

  // loop advance
  logic p1_end, n_end, m_end;
  assign p1_end = brk_q || (p1_q == p1_hi_w);
  assign n_end  = !ser_q || (n_q == 3'(SER_N_HI));
  assign m_end  = (m_q == m_hi_w) || (ser_q && best_err == '0);

  // encoding of winner
  logic [WORD_W-1:0] enc_div, enc_ctl;
  pllsrch_enc #(.WORD_W(WORD_W)) u_enc (
    .serial  (ser_q),
    .have    (have_q),
    .m       (bm),
    .n       (bn),
    .p1      (bp),
    .div_word(enc_div),
    .ctl_word(enc_ctl)
  );

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tgt_q    <= '0;
      ser_q    <= 1'b0;
      lim_q    <= '0;
      m_q      <= '0;
      n_q      <= '0;
      p1_q     <= '0;
      best_err <= '0;
      bm       <= '0;
      bn       <= '0;
      bp       <= '0;
      have_q   <= 1'b0;
      brk_q    <= 1'b0;
      done     <= 1'b0;
      found    <= 1'b0;
      div_word <= '0;
      ctl_word <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          tgt_q    <= target_khz;
          ser_q    <= serial_mode;
          lim_q    <= new_lim;
          m_q      <= serial_mode ? 8'(SER_M_LO) : new_lim.m_lo;
          p1_q     <= serial_mode ? 4'(SER_P1_LO) : new_lim.p1_lo;
          n_q      <= 3'(SER_N_LO);
          best_err <= serial_mode ? EW'(SER_ERR_INIT) : EW'(target_khz);
          bm       <= '0;
          bn       <= '0;
          bp       <= '0;
          have_q   <= 1'b0;
          brk_q    <= 1'b0;
          st       <= S_EVAL;
        end
        S_EVAL: begin
          if (ser_q && vco_hi) begin
            brk_q <= 1'b1;
            st    <= S_ADV;
          end else if (ser_q && vco_lo) begin
            brk_q <= 1'b0;
            st    <= S_ADV;
          end else begin
            st <= S_WAIT1;
          end
        end
        S_WAIT1: if (div_ok) begin
          if (ser_q) st <= S_WAIT2;
          else begin
            brk_q <= 1'b0;
            st    <= S_ADV;
          end
        end
        S_WAIT2: if (div_ok) begin
          brk_q <= cand_abandon;
          st    <= S_ADV;
        end
        S_ADV: begin
          brk_q <= 1'b0;
          if (!p1_end) begin
            p1_q <= p1_q + 4'd1;
            st   <= S_EVAL;
          end else begin
            p1_q <= p1_lo_w;
            if (!n_end) begin
              n_q <= n_q + 3'd1;
              st  <= S_EVAL;
            end else begin
              n_q <= 3'(SER_N_LO);
              if (m_end) st <= S_FIN;
              else begin
                m_q <= m_q + 8'd1;
                st  <= S_EVAL;
              end
            end
          end
        end
        S_FIN: begin
          found    <= ser_q ? (best_err == '0) : (best_err != EW'(tgt_q));
          div_word <= enc_div;
          ctl_word <= enc_ctl;
          done     <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (cand_improve) begin
        best_err <= err_abs;
        bm       <= m_q;
        bn       <= n_q;
        bp       <= p1_q;
        have_q   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pllsrch_chk.sv
module pllsrch_chk #(
  parameter int TGT_W = 18
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    busy,
  input logic                    done,
  input logic                    found,
  input logic [31:0]             div_word,
  input logic [31:0]             ctl_word,
  input logic                    ser_q,
  input logic                    have_q,
  input logic                    div_go,
  input logic                    div_busy,
  input logic signed [TGT_W+15:0] best_err
);

  a_r2_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(found) && $stable(div_word) && $stable(ctl_word)));

  a_r3_best_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (best_err <= $past(best_err)));

  a_r5_zero_when_lost: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ser_q && !found) |-> (div_word == 32'd0 && ctl_word == 32'd0));

  a_r6_panel_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ser_q && found) |-> ($onehot(ctl_word[23:17]) && div_word[7:0] == 8'd0
                                   && div_word[31:16] == 16'd0));

  a_r9_serial_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ser_q && have_q) |-> ($onehot(div_word[22:18]) && div_word[31:23] == 9'd0
                                   && $onehot(ctl_word[17:16])));

  a_r9_ctl_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl_word));

  a_r3_div_free: assert property (@(posedge clk) disable iff (!rst_n)
    div_go |-> !div_busy);

endmodule

bind pllsrch_top pllsrch_chk #(.TGT_W(TGT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .done    (done),
  .found   (found),
  .div_word(div_word),
  .ctl_word(ctl_word),
  .ser_q   (ser_q),
  .have_q  (have_q),
  .div_go  (div_go),
  .div_busy(div_busy),
  .best_err(best_err)
);

// File: tb/tb_pllsrch_top.sv
module tb_pllsrch_top;
  localparam int TCLK  = 10;
  localparam int TGT_W = 18;
  localparam int WDOG  = 195000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [TGT_W-1:0] target_khz = '0;
  logic             serial_mode = 1'b0;
  logic [1:0]       core_sel = 2'd0;
  logic             busy, done, found;
  logic [31:0]      div_word, ctl_word;

  int checks = 0;
  int errors = 0;

  always #(TCLK/2) clk = ~clk;

  pllsrch_top #(.TGT_W(TGT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .target_khz(target_khz),
    .serial_mode(serial_mode), .core_sel(core_sel), .busy(busy), .done(done),
    .found(found), .div_word(div_word), .ctl_word(ctl_word)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  // m code: register of 6 bits moving right, new top bit from bits 0 and 5
  function automatic int code_of(input int k);
    int s = 43;
    for (int i = 0; i < k; i++) s = (s >> 1) | (((s ^ (s >> 5)) & 1) << 5);
    return s;
  endfunction

  // arithmetic reference search
  task automatic expect_of(input bit ser, input int cs, input int t,
                           output bit ef, output longint ed, output longint ec);
    longint best, e, act, vco, dot, rf;
    int bm = 0, bn = 0, bp = 0, mlo, mhi, plo, phi;
    bit have = 0;
    ed = 0; ec = 0;
    if (!ser) begin
      if (cs == 0)      begin rf = 100000; mlo = 20; mhi = 34; plo = 2; phi = 8; end
      else if (cs == 1) begin rf = 166000; mlo = 12; mhi = 20; plo = 2; phi = 7; end
      else              begin rf = 200000; mlo = 10; mhi = 17; plo = 2; phi = 8; end
      best = t;
      for (int m = mlo; m <= mhi; m++)
        for (int p = plo; p <= phi; p++) begin
          dot = (rf * m) / (14 * p);
          e = dot > t ? dot - t : t - dot;
          if (e < best) begin best = e; bm = m; bp = p; have = 1; end
        end
      ef = (best != t);
      if (have) begin
        ed = longint'(code_of(bm - 10)) << 8;
        ec = longint'(1) << (17 + bp - 2);
      end
    end else begin
      best = 100000;
      for (int m = 80; m <= 137; m++) begin
        for (int n = 3; n <= 7; n++)
          for (int p = 1; p <= 2; p++) begin
            vco = longint'(t) * (p * 10);
            if (vco > 2800000) break;
            if (vco < 1400000) continue;
            act = (96000 * longint'(m)) / (n * p * 10);
            e = 10000 - (longint'(t) * 10000) / act;
            if (e < -best) break;
            if (e < 0) e = -e;
            if (e < best) begin best = e; bm = m; bn = n; bp = p; have = 1; end
          end
        if (best == 0) break;
      end
      ef = (best == 0);
      if (have) begin
        ed = ((longint'(1) << (bn - 1)) << 16) | longint'(bm - 2);
        ec = (longint'(1) << (bp - 1)) << 16;
      end
    end
  endtask

  task automatic launch(input bit ser, input int cs, input int t);
    start = 1'b1; serial_mode = ser; core_sel = 2'(cs); target_khz = TGT_W'(t);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic judge(input string rq, input bit ef, input longint ed, input longint ec);
    chk(found == ef, {rq, " found"}, longint'(found), longint'(ef));
    chk(div_word == 32'(ed), {rq, " div_word"}, longint'(div_word), ed);
    chk(ctl_word == 32'(ec), {rq, " ctl_word"}, longint'(ctl_word), ec);
  endtask

  task automatic run(input bit ser, input int cs, input int t, input string rq);
    bit ef; longint ed, ec;
    expect_of(ser, cs, t, ef, ed, ec);
    @(negedge clk);
    launch(ser, cs, t);
    chk(busy == 1'b1, "R2 busy after start", longint'(busy), 1);
    wait_done();
    judge(rq, ef, ed, ec);
    @(negedge clk);
    chk(done == 1'b0, "R2 done one cycle", longint'(done), 0);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ef; longint ed, ec;
    bit ef2; longint ed2, ec2;
    int pan_t[5] = '{19750, 47000, 83333, 120000, 150000};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0 && found == 0, "R1 flags in reset", longint'({busy, done, found}), 0);
    chk(div_word == 0 && ctl_word == 0, "R1 words in reset", longint'(div_word | ctl_word), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && div_word == 0, "R1 after release", longint'(div_word), 0);

    // R3 R4 R6 panel sweeps across every core selection
    for (int cs = 0; cs < 3; cs++)
      for (int k = 0; k < 5; k++) run(0, cs, pan_t[k], "R3 R4 R6 panel");
    run(0, 3, 83333, "R4 core_sel 3");
    run(0, 3, 47000, "R4 core_sel 3");

    // R5 panel with no improving candidate
    run(0, 0, 1, "R5 no candidate");
    run(0, 2, 0, "R5 zero target");

    // R11 outputs hold while idle
    repeat (6) @(negedge clk);
    chk(div_word == 0 && ctl_word == 0 && found == 0, "R11 hold", longint'(div_word), 0);

    // R7 R8 R9 serial mode
    run(1, 0, 256000, "R8 R9 serial exact");
    run(1, 1, 100, "R7 R9 serial below window");
    run(1, 0, 150000, "R7 R8 serial window p1=1");
    run(1, 2, 100000, "R7 R8 serial window p1=2");

    // R2 start while busy is ignored
    expect_of(0, 0, 55555, ef, ed, ec);
    @(negedge clk);
    launch(0, 0, 55555);
    repeat (40) @(negedge clk);
    chk(busy == 1'b1, "R2 still busy", longint'(busy), 1);
    launch(1, 1, 256000);
    wait_done();
    judge("R2 start during busy", ef, ed, ec);
    chk(serial_mode == 1'b1, "R2 stimulus applied", longint'(serial_mode), 1);

    // R10 start in the same cycle as done
    expect_of(0, 1, 90000, ef, ed, ec);
    expect_of(0, 2, 30000, ef2, ed2, ec2);
    @(negedge clk);
    launch(0, 1, 90000);
    wait_done();
    judge("R10 first", ef, ed, ec);
    launch(0, 2, 30000);
    chk(busy == 1'b1, "R10 accepted at done", longint'(busy), 1);
    target_khz = TGT_W'(77777); core_sel = 2'd0;
    wait_done();
    judge("R10 second", ef2, ed2, ec2);
    repeat (4) @(negedge clk);
    chk(div_word == 32'(ed2) && ctl_word == 32'(ec2), "R11 hold after R10", longint'(div_word), ed2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule